// File: doc/BRIEF.md
# UART Sleep-Mode Power Controller

This block decides when a UART core may be put to sleep. It drives a sleep level that a surrounding clock-gating stage uses to stop the baud clock and the oscillator. Sleep is armed only when two separate register enable bits are both set. While armed, the block sleeps whenever the transmitter and receiver have no pending work and no interrupt is pending.

Sleep ends as soon as something happens. A start bit arriving on the serial receive line ends it, as does an edge in either direction on any modem status input or a host write into the transmit holding register. When sleep ends this way, a one-cycle wake pulse is raised. After the resulting traffic has drained, the block goes back to sleep without any software action. Clearing either enable bit keeps the core awake until the bit is set again.

The receive line and the modem inputs are asynchronous. Each passes through a two-flop synchronizer. An edge is detected by comparing the synchronized value against its value one clock earlier.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: `sleepOut` can be high only while `featEnable` and `sleepEnable` are both 1. When the second of the two bits becomes 1 with the core drained and no interrupt pending, `sleepOut` rises at the next clock edge.
- R2: A falling edge on `rxLine` while asleep drops `sleepOut` and raises `wakePulse` in the cycle after the second clock edge following the edge. A rising edge on `rxLine` has no effect.
- R3: A change in either direction on any bit of `modemIn` (bits 0..3) while asleep drops `sleepOut` and raises `wakePulse` in the cycle after the second clock edge following the change.
- R4: `hostTxWrite` high while asleep drops `sleepOut` and raises `wakePulse` in the same cycle, with no clock edge in between.
- R5: "Drained" means `txHoldEmpty`, `txShiftIdle` and `rxFifoEmpty` are all 1. Once drained holds again after a wake, sleep returns with no software action. `sleepOut` rises at the second clock edge after drained becomes true, so drained must hold for one full cycle first.
- R6: While `irqPending` is 1, `sleepOut` is 0 in the same cycle. After `irqPending` clears with the core drained, `sleepOut` rises at the next clock edge.
- R7: Clearing `sleepEnable` or `featEnable` drops `sleepOut` in the same cycle, without a wake pulse. While either bit is 0, no receive, modem or host event raises `wakePulse`.
- R8: `wakePulse` lasts exactly one cycle and is raised only when an event ends actual sleep. A host write while already awake gives no pulse.
- R9: After reset, `sleepOut` and `wakePulse` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| featEnable | input | 1 | Enhanced-feature enable bit that permits sleep |
| sleepEnable | input | 1 | Interrupt-enable register bit that arms sleep |
| irqPending | input | 1 | Some UART interrupt is pending |
| rxLine | input | 1 | Serial receive line, idle high, asynchronous |
| modemIn | input | 4 | Modem status inputs (ring, clear-to-send, data-set-ready, carrier), asynchronous |
| hostTxWrite | input | 1 | Host write strobe to the transmit holding register |
| txHoldEmpty | input | 1 | Transmit holding register is empty |
| txShiftIdle | input | 1 | Transmit shift register is idle |
| rxFifoEmpty | input | 1 | Receive FIFO is empty |
| sleepOut | output | 1 | High while the core may sleep |
| wakePulse | output | 1 | One-cycle pulse when an event ends sleep |

## Verification
The results arrive at different times, and each check is placed to match.

- **Host writes, interrupts and enable bits.** These act in the same cycle as the stimulus, so the bench checks in that cycle.
- **Receive-line and modem edges.** These travel through two synchronizer flops and an edge register. The wake is therefore expected in the cycle after the second edge, and re-sleep two edges after that.
- **Re-sleep after traffic.** This comes two edges after the drained inputs all return to 1.

Every stimulus task queues its expected samples tagged with an absolute cycle number. A monitor then compares them mid-cycle, away from the active edge. Queued samples in between also confirm that nothing changes early.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  // Wake strobes handed from the datapath to the control
  typedef struct packed {
    logic rxStart;
    logic modemChange;
    logic hostWrite;
  } wakeEvt_t;
endpackage

// File: rtl/sleep_wake_detect.sv
module sleep_wake_detect
  import sleep_pkg::*;
#(
  parameter int MODEM_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxLine,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic               hostTxWrite,
  output wakeEvt_t           evt
);
  localparam int VEC_W = MODEM_W + 1;
  // bit 0 is the receive line (idle high), the rest are modem inputs
  localparam logic [VEC_W-1:0] RST_VAL = {{MODEM_W{1'b0}}, 1'b1};

  logic [VEC_W-1:0]                  rawVec;
  logic [SYNC_STAGES-1:0][VEC_W-1:0] stageQ;
  logic [VEC_W-1:0]                  syncVec;
  logic [VEC_W-1:0]                  prevVec;
  logic [MODEM_W-1:0]                modemDiff;

  assign rawVec  = {modemIn, rxLine};
  assign syncVec = stageQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) stageQ[s] <= RST_VAL;
      prevVec <= RST_VAL;
    end else begin
      stageQ[0] <= rawVec;
      for (int s = 1; s < SYNC_STAGES; s++) stageQ[s] <= stageQ[s-1];
      prevVec <= syncVec;
    end
  end

  generate
    for (genvar i = 0; i < MODEM_W; i++) begin : g_modemEdge
      assign modemDiff[i] = syncVec[i+1] ^ prevVec[i+1];
    end
  endgenerate

  assign evt.rxStart     = prevVec[0] & ~syncVec[0];
  assign evt.modemChange = |modemDiff;
  assign evt.hostWrite   = hostTxWrite;
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     featEnable,
  input  logic     sleepEnable,
  input  logic     irqPending,
  input  wakeEvt_t evt,
  input  logic     txHoldEmpty,
  input  logic     txShiftIdle,
  input  logic     rxFifoEmpty,
  output logic     sleepOut,
  output logic     wakePulse
);
  typedef enum logic {ST_AWAKE = 1'b0, ST_ASLEEP = 1'b1} sleepState_e;

  sleepState_e state;
  logic armed, wakeCond, drained, drainedQ, mayEnter;

  assign armed    = featEnable & sleepEnable;
  assign wakeCond = evt.rxStart | evt.modemChange | evt.hostWrite;
  assign drained  = txHoldEmpty & txShiftIdle & rxFifoEmpty;
  assign mayEnter = armed & ~irqPending & drained & drainedQ & ~wakeCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_AWAKE;
      drainedQ <= 1'b0;
    end else begin
      drainedQ <= drained;
      state    <= mayEnter ? ST_ASLEEP : ST_AWAKE;
    end
  end

  assign sleepOut  = (state == ST_ASLEEP) & armed & ~irqPending & ~wakeCond;
  assign wakePulse = (state == ST_ASLEEP) & armed & wakeCond;

  AST_ARM_BEFORE_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepOut) |-> $past(featEnable && sleepEnable)); // R1
  AST_DRAIN_BEFORE_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepOut) |-> ($past(drained) && $past(drained, 2))); // R5
  AST_IRQ_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
    $past(irqPending) |-> !sleepOut); // R6
  AST_DISARM_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepEnable) |-> !sleepOut); // R7
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R8
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl (
  input  logic       clk,
  input  logic       rstN,
  input  logic       featEnable,
  input  logic       sleepEnable,
  input  logic       irqPending,
  input  logic       rxLine,
  input  logic [3:0] modemIn,
  input  logic       hostTxWrite,
  input  logic       txHoldEmpty,
  input  logic       txShiftIdle,
  input  logic       rxFifoEmpty,
  output logic       sleepOut,
  output logic       wakePulse
);
  sleep_pkg::wakeEvt_t evt;

  sleep_wake_detect #(.MODEM_W(4), .SYNC_STAGES(2)) uDetect (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .modemIn(modemIn),
    .hostTxWrite(hostTxWrite), .evt(evt)
  );

  sleep_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .featEnable(featEnable), .sleepEnable(sleepEnable),
    .irqPending(irqPending), .evt(evt), .txHoldEmpty(txHoldEmpty),
    .txShiftIdle(txShiftIdle), .rxFifoEmpty(rxFifoEmpty),
    .sleepOut(sleepOut), .wakePulse(wakePulse)
  );
endmodule

// File: tb/sim_uart_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_uart_sleep_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic featEnable = 1'b0, sleepEnable = 1'b0, irqPending = 1'b0;
  logic rxLine = 1'b1;
  logic [3:0] modemIn = 4'h0;
  logic hostTxWrite = 1'b0;
  logic txHoldEmpty = 1'b1, txShiftIdle = 1'b1, rxFifoEmpty = 1'b1;
  logic sleepOut, wakePulse;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int    at;
    bit    s;
    bit    w;
    string req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_sleep_ctrl u0 (
    .clk(clk), .rstN(rstN), .featEnable(featEnable), .sleepEnable(sleepEnable),
    .irqPending(irqPending), .rxLine(rxLine), .modemIn(modemIn),
    .hostTxWrite(hostTxWrite), .txHoldEmpty(txHoldEmpty),
    .txShiftIdle(txShiftIdle), .rxFifoEmpty(rxFifoEmpty),
    .sleepOut(sleepOut), .wakePulse(wakePulse)
  );

  // driver side: queue an expected sample off cycles from now
  task automatic expectAt(int off, bit s, bit w, string req);
    exp_t e;
    e.at = cyc + off; e.s = s; e.w = w; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: mid-cycle, after the drivers at the falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (e.at != cyc || sleepOut !== e.s || wakePulse !== e.w) begin
        fails++;
        $display("FAIL %s cycle %0d: sleep=%b wake=%b, expected sleep=%b wake=%b (due %0d)",
                 e.req, cyc, sleepOut, wakePulse, e.s, e.w, e.at);
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual running, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(2);
    expectAt(0, 0, 0, "R9");                    // reset state
    step(1); rstN = 1'b1;
    expectAt(1, 0, 0, "R9");
    step(4);

    // R1: one enable bit alone does not arm
    featEnable = 1'b1;
    expectAt(1, 0, 0, "R1"); expectAt(3, 0, 0, "R1");
    step(4); featEnable = 1'b0; sleepEnable = 1'b1;
    expectAt(1, 0, 0, "R1"); expectAt(3, 0, 0, "R1");
    step(4); featEnable = 1'b1;
    expectAt(0, 0, 0, "R1"); expectAt(1, 1, 0, "R1");
    step(3);

    // R4: host write wakes in the same cycle
    hostTxWrite = 1'b1; txHoldEmpty = 1'b0;
    expectAt(0, 0, 1, "R4");
    step(1); hostTxWrite = 1'b0;
    expectAt(0, 0, 0, "R8");
    step(1); hostTxWrite = 1'b1;              // R8: write while awake, no pulse
    expectAt(0, 0, 0, "R8");
    step(1); hostTxWrite = 1'b0;
    step(2); txHoldEmpty = 1'b1;               // R5: drained again
    expectAt(0, 0, 0, "R5"); expectAt(1, 0, 0, "R5"); expectAt(2, 1, 0, "R5");
    step(4);

    // R2: start bit through the synchronizer
    rxLine = 1'b0;
    expectAt(0, 1, 0, "R2"); expectAt(1, 1, 0, "R2"); expectAt(2, 0, 1, "R2");
    expectAt(3, 0, 0, "R8"); expectAt(4, 1, 0, "R5");
    step(6); rxLine = 1'b1;                    // rising edge: no effect
    expectAt(2, 1, 0, "R2"); expectAt(3, 1, 0, "R2"); expectAt(4, 1, 0, "R2");
    step(5);

    // R3: every modem bit, both directions
    for (int i = 0; i < 4; i++) begin
      for (int d = 1; d >= 0; d--) begin
        modemIn[i] = d[0];
        expectAt(1, 1, 0, "R3"); expectAt(2, 0, 1, "R3");
        expectAt(3, 0, 0, "R3"); expectAt(4, 1, 0, "R3");
        step(6);
      end
    end

    // R5: received character keeps the core awake until read
    rxLine = 1'b0;
    expectAt(2, 0, 1, "R2");
    step(2); rxFifoEmpty = 1'b0; rxLine = 1'b1;
    step(1); expectAt(0, 0, 0, "R5");
    step(3); rxFifoEmpty = 1'b1;
    expectAt(0, 0, 0, "R5"); expectAt(1, 0, 0, "R5"); expectAt(2, 1, 0, "R5");
    step(4);

    // R6: interrupt lockout
    irqPending = 1'b1;
    expectAt(0, 0, 0, "R6"); expectAt(2, 0, 0, "R6");
    step(3); irqPending = 1'b0;
    expectAt(0, 0, 0, "R6"); expectAt(1, 1, 0, "R6");
    step(3);

    // R7: disarm wakes at once and blocks wake pulses
    sleepEnable = 1'b0;
    expectAt(0, 0, 0, "R7");
    step(1); rxLine = 1'b0;
    expectAt(2, 0, 0, "R7"); expectAt(4, 0, 0, "R7");
    step(6); rxLine = 1'b1;
    step(4); expectAt(0, 0, 0, "R7");
    sleepEnable = 1'b1;
    expectAt(1, 1, 0, "R7");
    step(3); featEnable = 1'b0;
    expectAt(0, 0, 0, "R7"); expectAt(2, 0, 0, "R7");
    step(3); featEnable = 1'b1;
    expectAt(1, 1, 0, "R1");
    step(3);

    wait (q.size() == 0);
    step(2);
    done = 1;
    summary();
    $finish;
  end
endmodule